// File: doc/BRIEF.md
# Real-Constant Chunked Lookup Multiplier

This block multiplies a signed fixed-point sample by a real-valued constant that is fixed at elaboration time. The input word is cut into slices of `CHUNK_W` bits. Each slice addresses its own small table of partial products. Every table entry is the exact product of the constant and one slice value, rounded once to the nearest multiple of the guard-extended output LSB. The table outputs are aligned by weight and summed without further rounding. The result is a signed word whose LSB weighs 2^-(`OUT_LSB`+`GUARD`). The caller drops the `GUARD` low bits after its own final rounding.

The constant is given as a signed integer `K_VAL` scaled by 2^-`K_FRAC`. `K_FRAC` should exceed `OUT_LSB`+`GUARD`+`CHUNK_W`+8 so that the quantisation of the constant stays far below the output LSB. The top slice is signed two's complement. All lower slices are unsigned. The block computes the table contents at elaboration, so the lower-weight tables are narrower than the top one. One register stage follows the lookup and one follows the sum, and a valid bit travels alongside the data.

Top module: `real_const_kcm`

## Requirements
- R1: `valid_o` equals `valid_i` delayed by exactly two clock cycles. A sample presented with `valid_i` high appears on `y_o` in the same cycle that its `valid_o` goes high.
- R2: While `rst_n` is low, and in the first sample after reset, `valid_o` is 0 and `y_o` is 0.
- R3: For every input X (two's complement, LSB 2^-`IN_FRAC`), the output Y (two's complement, LSB 2^-(`OUT_LSB`+`GUARD`)) satisfies |Y·2^-(OUT_LSB+GUARD) − a·X·2^-IN_FRAC| ≤ n·2^-(OUT_LSB+GUARD+1). Here a = `K_VAL`·2^-`K_FRAC` and n = ceil(`IN_W`/`CHUNK_W`).
- R4: An all-zero input word gives an all-zero output word.
- R5: When every bit below the top slice is zero, only one table contributes. The output then equals the product a·x rounded half-up, once, at weight 2^-(OUT_LSB+GUARD).
- R6: With a non-negative constant, a non-negative input (sign bit `x_i[IN_W-1]` clear) never yields a negative output (sign bit `y_o[OUT_W-1]` clear).
- R7: A cycle with `valid_i` low ignores `x_i`. While `valid_o` is low, `y_o` holds the last valid result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Input sample qualifier |
| x_i | input | IN_W | Signed input sample, LSB 2^-IN_FRAC |
| valid_o | output | 1 | Output result qualifier |
| y_o | output | OUT_W | Signed product, LSB 2^-(OUT_LSB+GUARD) |

## Verification
Two things happen in one cycle during a back-to-back stream. A new sample is looked up and captured into the first stage, and the sum of the previous sample is written to the output. So a mix-up between stages would pair a result with the wrong input. The bench sweeps all input codes with one bubble cycle every seven cycles. During bubbles it drives unrelated junk on `x_i`. This places streaming cycles and hold cycles next to each other. Every output sample is judged against the input driven two cycles earlier, using the error bound. Exact values are also checked for zero inputs and for inputs whose lower slices are zero. During bubbles the bench checks that `valid_o` stays low and that `y_o` holds its last value.

// File: rtl/kcm_pkg.sv
`timescale 1ns/1ps
package kcm_pkg;

    // Product of constant k and slice value d, scaled by 2^-shift and rounded half-up.
    function automatic logic signed [127:0] kcm_entry(input logic signed [63:0] k,
                                                      input logic signed [63:0] d,
                                                      input int shift);
        logic signed [127:0] kk;
        logic signed [127:0] dd;
        logic signed [127:0] prod;
        kk = {{64{k[63]}}, k};
        dd = {{64{d[63]}}, d};
        prod = kk * dd;
        if (shift > 0) begin
            prod = (prod + (128'sd1 <<< (shift - 1))) >>> shift;
        end else begin
            prod = prod <<< (-shift);
        end
        return prod;
    endfunction

endpackage

// File: rtl/kcm_table.sv
`timescale 1ns/1ps
module kcm_table #(
    parameter int AW        = 6,
    parameter int TW        = 12,
    parameter int OUT_W     = 17,
    parameter bit IS_SIGNED = 1'b0,
    parameter longint K_VAL = 64'sd3037000500,
    parameter int SHIFT     = 28
) (
    input  logic [AW-1:0]           addr_i,
    output logic signed [OUT_W-1:0] entry_o
);
    localparam int DEPTH = 1 << AW;

    logic signed [TW-1:0] rom [DEPTH];
    logic signed [TW-1:0] sel;

    for (genvar i = 0; i < DEPTH; i++) begin : g_rom
        localparam longint DVAL = (IS_SIGNED && (i >= DEPTH / 2)) ? longint'(i - DEPTH) : longint'(i);
        localparam logic signed [127:0] WIDE = kcm_pkg::kcm_entry(K_VAL, DVAL, SHIFT);
        assign rom[i] = WIDE[TW-1:0];
    end

    assign sel     = rom[addr_i];
    assign entry_o = OUT_W'(sel);
endmodule

// File: rtl/kcm_sum.sv
`timescale 1ns/1ps
module kcm_sum #(
    parameter int N = 2,
    parameter int W = 17
) (
    input  logic [N-1:0][W-1:0] terms_i,
    output logic [W-1:0]        total_o
);
    logic [W-1:0] acc;

    always_comb begin
        acc = '0;
        for (int i = 0; i < N; i++) begin
            acc = acc + terms_i[i];
        end
        total_o = acc;
    end
endmodule

// File: rtl/real_const_kcm.sv
`timescale 1ns/1ps
module real_const_kcm #(
    parameter int IN_W      = 12,
    parameter int IN_FRAC   = 11,
    parameter int CHUNK_W   = 6,
    parameter int OUT_LSB   = 12,
    parameter int GUARD     = 3,
    parameter int OUT_W     = 17,
    parameter longint K_VAL = 64'sd3037000500,
    parameter int K_FRAC    = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             valid_i,
    input  logic [IN_W-1:0]  x_i,
    output logic             valid_o,
    output logic [OUT_W-1:0] y_o
);
    localparam int RES  = OUT_LSB + GUARD;
    localparam int NCH  = (IN_W + CHUNK_W - 1) / CHUNK_W;
    localparam int TOPW = IN_W - (NCH - 1) * CHUNK_W;
    localparam int S0   = K_FRAC + IN_FRAC - RES;

    typedef struct packed {
        logic                       v1;
        logic [NCH-1:0][OUT_W-1:0]  p1;
        logic                       v2;
        logic [OUT_W-1:0]           y;
    } state_t;

    state_t st_d, st_q;
    logic [NCH-1:0][OUT_W-1:0] parts;
    logic [OUT_W-1:0]          total;

    for (genvar k = 0; k < NCH; k++) begin : g_chunk
        localparam bit TOP = (k == NCH - 1);
        localparam int AW  = TOP ? TOPW : CHUNK_W;
        localparam int NW  = OUT_W - (NCH - 1 - k) * CHUNK_W + (CHUNK_W - TOPW) + 2;
        localparam int TW  = TOP ? OUT_W : ((NW < OUT_W) ? ((NW < 4) ? 4 : NW) : OUT_W);
        logic signed [OUT_W-1:0] entry;

        kcm_table #(
            .AW(AW), .TW(TW), .OUT_W(OUT_W), .IS_SIGNED(TOP),
            .K_VAL(K_VAL), .SHIFT(S0 - k * CHUNK_W)
        ) i_table (
            .addr_i  (x_i[k*CHUNK_W +: AW]),
            .entry_o (entry)
        );
        assign parts[k] = entry;
    end

    kcm_sum #(.N(NCH), .W(OUT_W)) i_sum (
        .terms_i (st_q.p1),
        .total_o (total)
    );

    always_comb begin
        st_d    = st_q;
        st_d.v1 = valid_i;
        st_d.v2 = st_q.v1;
        if (valid_i) begin
            st_d.p1 = parts;
        end
        if (st_q.v1) begin
            st_d.y = total;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign valid_o = st_q.v2;
    assign y_o     = st_q.y;
endmodule

// File: rtl/kcm_checker.sv
`timescale 1ns/1ps
module kcm_checker #(
    parameter int IN_W      = 12,
    parameter int OUT_W     = 17,
    parameter longint K_VAL = 64'sd3037000500
) (
    input logic             clk,
    input logic             rst_n,
    input logic             valid_i,
    input logic [IN_W-1:0]  x_i,
    input logic             valid_o,
    input logic [OUT_W-1:0] y_o
);
    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n) valid_o == $past(valid_i, 2)); // R1

    AST_ZERO_IN_ZERO_OUT: assert property (@(posedge clk) disable iff (!rst_n) (valid_o && ($past(x_i, 2) == '0)) |-> (y_o == '0)); // R4

    AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !valid_o |-> $stable(y_o)); // R7

    AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |-> (!valid_o && (y_o == '0))); // R2

    if (K_VAL >= 0) begin : g_pos
        AST_SIGN_NONNEG: assert property (@(posedge clk) disable iff (!rst_n) (valid_o && !$past(x_i[IN_W-1], 2)) |-> !y_o[OUT_W-1]); // R6
    end
endmodule

bind real_const_kcm kcm_checker #(
    .IN_W(IN_W), .OUT_W(OUT_W), .K_VAL(K_VAL)
) i_kcm_checker (
    .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .x_i(x_i),
    .valid_o(valid_o), .y_o(y_o)
);

// File: tb/test_real_const_kcm.sv
`timescale 1ns/1ps
module test_real_const_kcm;
    localparam int IN_W      = 12;
    localparam int IN_FRAC   = 11;
    localparam int CHUNK_W   = 6;
    localparam int OUT_LSB   = 12;
    localparam int GUARD     = 3;
    localparam int OUT_W     = 17;
    localparam longint K_VAL = 64'sd3037000500;
    localparam int K_FRAC    = 32;
    localparam int NCH       = (IN_W + CHUNK_W - 1) / CHUNK_W;
    localparam int S0        = K_FRAC + IN_FRAC - OUT_LSB - GUARD;
    localparam int NCODES    = 1 << IN_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic valid_i = 1'b0;
    logic [IN_W-1:0] x_i = '0;
    logic valid_o;
    logic [OUT_W-1:0] y_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic hv [4];
    logic [IN_W-1:0] hx [4];
    logic [OUT_W-1:0] last_y;

    always #10 clk = ~clk;

    real_const_kcm #(
        .IN_W(IN_W), .IN_FRAC(IN_FRAC), .CHUNK_W(CHUNK_W), .OUT_LSB(OUT_LSB),
        .GUARD(GUARD), .OUT_W(OUT_W), .K_VAL(K_VAL), .K_FRAC(K_FRAC)
    ) i_real_const_kcm (
        .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .x_i(x_i),
        .valid_o(valid_o), .y_o(y_o)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic judge(input int c);
        longint xs, ys, err, lim, ref5;
        int idx;
        idx = (c - 2) & 3;
        check(valid_o == hv[idx], "R1", longint'(valid_o), longint'(hv[idx]));
        ys = longint'($signed(y_o));
        if (hv[idx]) begin
            xs  = longint'($signed(hx[idx]));
            err = ys * (64'sd1 <<< S0) - K_VAL * xs;
            if (err < 0) err = -err;
            lim = longint'(NCH) * (64'sd1 <<< (S0 - 1));
            check(err <= lim, "R3", ys, (K_VAL * xs) >>> S0);
            if (xs == 0) check(ys == 0, "R4", ys, 0);
            if (hx[idx][CHUNK_W-1:0] == '0) begin
                ref5 = (K_VAL * xs + (64'sd1 <<< (S0 - 1))) >>> S0;
                check(ys == ref5, "R5", ys, ref5);
            end
            if (xs >= 0) check(ys >= 0, "R6", ys, 0);
        end else begin
            check(y_o == last_y, "R7", ys, longint'($signed(last_y)));
        end
        last_y = y_o;
    endtask

    initial begin
        int sent;
        int c;
        for (int i = 0; i < 4; i++) begin
            hv[i] = 1'b0;
            hx[i] = '0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(valid_o == 1'b0, "R2", longint'(valid_o), 0);
        check(y_o == '0, "R2", longint'(y_o), 0);
        rst_n = 1'b1;
        last_y = y_o;
        sent = 0;
        c = 0;
        while (sent < NCODES || c < 2 || hv[(c - 1) & 3] || hv[(c - 2) & 3]) begin
            @(negedge clk);
            if (c >= 2) judge(c);
            if (sent < NCODES && (c % 7) != 3) begin
                valid_i = 1'b1;
                x_i = IN_W'(sent);
                sent++;
            end else begin
                valid_i = 1'b0;
                x_i = IN_W'(c * 37 + 5);
            end
            hv[c & 3] = valid_i;
            hx[c & 3] = x_i;
            c++;
        end
        @(negedge clk);
        judge(c);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule